// File: doc/BRIEF.md
# Two-Rate Token-Bucket Ingress Meter

This block meters received packets against two token buckets, a committed one and a peak one, and returns a color with a pass or drop verdict for every packet. Each bucket's refill amount and depth use a compact float-like code: an 8-bit mantissa M and a 5-bit exponent E give (1 + M/256) · 2^E tokens, where one token is one byte. A time-unit strobe comes from outside, and a shared power-of-two divider spaces the refills. A length-mode bit and a signed adjust term set the cost of each packet, so the same buckets can meter bytes per second or packets per second.

Software sets up the single profile through a small write port with four registers. The receive path presents a packet as a one-cycle valid pulse with its byte length, a header offset and an optional pre-assigned color. On the next clock the meter returns the color and the action that this profile sets for that color.

Top module: `ingress_meter`

## Requirements
- R1: After reset, both buckets have exponent 24 (empty), the mode is color-blind, green and yellow pass (action 2'b00) and red drops (action 2'b01). A packet sent then is red with action 2'b01.
- R2: Each refill adds (256+M)·2^E/256 tokens to a bucket from its rate fields. Any exponent of 24 or more gives zero.
- R3: A refill happens on the strobe that completes each group of 2^RDIV strobes (RDIV = register 3 bits [3:0]). Any configuration write restarts the count.
- R4: A bucket never holds more than its depth (256+M)·2^E/256 tokens. An exponent of 24 or more gives depth zero.
- R5: The cost in byte mode is max(net + (AM−256)·2^AE/256, 1/256) tokens, where net = length − offset, or 0 when offset ≥ length. AM is register 2 bits [8:0] and AE is bits [20:16]. An AE of 24 or more drops the adjust term.
- R6: With the length-mode bit (register 2 bit 24) set, the length term is zero. AM=384 with AE=1 then costs exactly one token per packet.
- R7: A peak bucket whose exponents are 24 or more never holds tokens, so only green or red results occur.
- R8: A packet is green (2'b00) if the committed bucket holds at least its cost, and only that bucket is debited. Otherwise it is yellow (2'b01) if the peak bucket covers the cost, and only the peak bucket is debited. Otherwise it is red (2'b10) and no bucket changes.
- R9: With initial-color field (register 3 bits [9:8]) equal to 3, the input color is ignored. Otherwise an input color of red gives red, and an input color of yellow skips the committed test.
- R10: The action is the 2-bit field for the result color: green at register 3 bits [17:16], yellow at [19:18] and red at [21:20].
- R11: A write to register 0 (committed: rate M [7:0], rate E [12:8], depth M [23:16], depth E [28:24]), to register 1 (peak, same layout), to register 2 or to register 3 fills both buckets to their new depth on the following cycle.
- R12: The result is valid exactly one cycle after each packet pulse, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register index 0..3 |
| cfg_wdata | input | 32 | Register write data |
| tick | input | 1 | Time-unit strobe |
| pkt_valid | input | 1 | Packet present this cycle |
| pkt_len | input | 16 | Packet length in bytes |
| pkt_ofs | input | 8 | Bytes excluded from metering |
| pkt_color | input | 2 | Pre-assigned color: 0 green, 1 yellow, 2 red |
| res_valid | output | 1 | Result present |
| res_color | output | 2 | Result color: 0 green, 1 yellow, 2 red |
| res_action | output | 2 | Action field for the result color |

## Verification
A behavioural model in the bench holds both buckets as plain integers and is compared on every clock. The first stimulus is a reset followed by a single packet, which checks the empty defaults. A large packet followed by a small one against a 1024-token bucket, with no refills, separates the green test from debiting and from the red case. Trains of strobes under several divider values, with packets between them, test the refill period and the depth cap. They are followed by fractional and negative adjust terms, offsets past the length, packet-rate mode, color-aware inputs, a remapped action table and a long run of random traffic mixing all of these.

// File: rtl/ingress_meter.sv
module ingress_meter #(
  parameter int LEN_W  = 16,
  parameter int OFS_W  = 8,
  parameter int DATA_W = 32,
  parameter int BKT_W  = 40,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              tick,
  input  logic              pkt_valid,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [OFS_W-1:0]  pkt_ofs,
  input  logic [1:0]        pkt_color,
  output logic              res_valid,
  output logic [1:0]        res_color,
  output logic [1:0]        res_action
);
  localparam int SW = BKT_W + 1;

  function automatic logic [BKT_W-1:0] fp_val(input logic [7:0] m, input logic [4:0] e);
    return (e >= 5'd24) ? '0 : (BKT_W'({1'b1, m}) << e);
  endfunction

  logic [7:0] c_rm, c_dm, p_rm, p_dm;
  logic [4:0] c_re, c_de, p_re, p_de, adj_e;
  logic [8:0] adj_m;
  logic       lmode;
  logic [3:0] rdiv;
  logic [1:0] icol, act_g, act_y, act_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c_rm <= '0; c_re <= 5'd24; c_dm <= '0; c_de <= 5'd24;
      p_rm <= '0; p_re <= 5'd24; p_dm <= '0; p_de <= 5'd24;
      adj_m <= 9'd256; adj_e <= '0; lmode <= 1'b0;
      rdiv <= '0; icol <= 2'd3; act_g <= 2'd0; act_y <= 2'd0; act_r <= 2'd1;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: {c_de, c_dm, c_re, c_rm} <= {cfg_wdata[28:24], cfg_wdata[23:16], cfg_wdata[12:8], cfg_wdata[7:0]};
        2'd1: {p_de, p_dm, p_re, p_rm} <= {cfg_wdata[28:24], cfg_wdata[23:16], cfg_wdata[12:8], cfg_wdata[7:0]};
        2'd2: {lmode, adj_e, adj_m} <= {cfg_wdata[24], cfg_wdata[20:16], cfg_wdata[8:0]};
        default: {act_r, act_y, act_g, icol, rdiv} <=
                 {cfg_wdata[21:16], cfg_wdata[9:8], cfg_wdata[3:0]};
      endcase
    end

  wire [BKT_W-1:0] c_rate = fp_val(c_rm, c_re);
  wire [BKT_W-1:0] c_cap  = fp_val(c_dm, c_de);
  wire [BKT_W-1:0] p_rate = fp_val(p_rm, p_re);
  wire [BKT_W-1:0] p_cap  = fp_val(p_dm, p_de);

  logic [CNT_W-1:0] tick_cnt;
  logic             reload;
  wire refill = tick && (tick_cnt == (CNT_W'(1) << rdiv) - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tick_cnt <= '0;
      reload   <= 1'b1;
    end else begin
      reload <= cfg_we;
      if (cfg_we)    tick_cnt <= '0;
      else if (tick) tick_cnt <= refill ? '0 : tick_cnt + CNT_W'(1);
    end

  wire [LEN_W-1:0] net_len = (pkt_len > LEN_W'(pkt_ofs)) ? pkt_len - LEN_W'(pkt_ofs) : '0;
  wire signed [9:0]    adj_d    = $signed({1'b0, adj_m}) - 10'sd256;
  wire signed [SW-1:0] len_part = lmode ? '0 : $signed(SW'(net_len) << 8);
  wire signed [SW-1:0] adj_part = (adj_e >= 5'd24) ? '0 : (SW'(adj_d) <<< adj_e);
  wire signed [SW-1:0] cost_raw = len_part + adj_part;
  wire [BKT_W-1:0]     cost     = (cost_raw > 0) ? BKT_W'(cost_raw) : BKT_W'(1);

  logic [BKT_W-1:0] c_bkt, p_bkt;
  wire [1:0] in_col = (icol == 2'd3) ? 2'd0 : pkt_color;
  wire take_g = (in_col != 2'd2) && (in_col != 2'd1) && (c_bkt >= cost);
  wire take_y = !take_g && (in_col != 2'd2) && (p_bkt >= cost);
  wire [1:0] col = take_g ? 2'd0 : take_y ? 2'd1 : 2'd2;

  wire [BKT_W-1:0] c_sum = c_bkt - ((pkt_valid && take_g) ? cost : '0) + (refill ? c_rate : '0);
  wire [BKT_W-1:0] p_sum = p_bkt - ((pkt_valid && take_y) ? cost : '0) + (refill ? p_rate : '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c_bkt <= '0;
      p_bkt <= '0;
    end else if (reload) begin
      c_bkt <= c_cap;
      p_bkt <= p_cap;
    end else begin
      c_bkt <= (c_sum > c_cap) ? c_cap : c_sum;
      p_bkt <= (p_sum > p_cap) ? p_cap : p_sum;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_color  <= 2'd0;
      res_action <= 2'd0;
    end else begin
      res_valid <= pkt_valid;
      res_color <= col;
      case (col)
        2'd0:    res_action <= act_g;
        2'd1:    res_action <= act_y;
        default: res_action <= act_r;
      endcase
    end

  a_r12_latency: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> res_valid);
  a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> !res_valid);
  a_r4_cap: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |-> (c_bkt <= c_cap) && (p_bkt <= p_cap));
  a_r3_no_gain_between_refills: assert property (@(posedge clk) disable iff (!rst_n)
    (!refill && !reload) |=> (c_bkt <= $past(c_bkt)) && (p_bkt <= $past(p_bkt)));
  a_r8_red_no_debit: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !reload && (col == 2'd2)) |=> (c_bkt >= $past(c_bkt)) && (p_bkt >= $past(p_bkt)));
  a_r9_red_stays_red: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && (icol != 2'd3) && (pkt_color == 2'd2)) |=> (res_color == 2'd2));
endmodule

// File: tb/ingress_meter_tb.sv
module ingress_meter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        tick = 1'b0;
  logic        pkt_valid = 1'b0;
  logic [15:0] pkt_len = '0;
  logic [7:0]  pkt_ofs = '0;
  logic [1:0]  pkt_color = '0;
  logic        res_valid;
  logic [1:0]  res_color, res_action;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  always #2 clk = ~clk;

  ingress_meter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .tick(tick), .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_ofs(pkt_ofs),
    .pkt_color(pkt_color), .res_valid(res_valid), .res_color(res_color), .res_action(res_action)
  );

  logic [31:0] mr[4];
  longint mc, mp;
  int     mcnt;
  bit     mreload;
  bit     ev;
  int     ecol, eact;

  function automatic longint fpv(int m, int e);
    return (e >= 24) ? 0 : (longint'(256 + m) << e);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mr[0] = {3'd0, 5'd24, 8'd0, 3'd0, 5'd24, 8'd0};
      mr[1] = mr[0];
      mr[2] = 32'd256;
      mr[3] = {10'd0, 2'd1, 2'd0, 2'd0, 6'd0, 2'd3, 4'd0, 4'd0};
      mc = 0; mp = 0; mcnt = 0; mreload = 1; ev = 0; ecol = 0; eact = 0;
    end else begin
      longint ccap, pcap, crate, prate, cost, nl, dc, dp;
      int rdiv, icol, incol, col, am, ae;
      bit lm, refill;
      crate = fpv(mr[0][7:0], mr[0][12:8]);  ccap = fpv(mr[0][23:16], mr[0][28:24]);
      prate = fpv(mr[1][7:0], mr[1][12:8]);  pcap = fpv(mr[1][23:16], mr[1][28:24]);
      am = mr[2][8:0]; ae = mr[2][20:16]; lm = mr[2][24];
      rdiv = mr[3][3:0]; icol = mr[3][9:8];
      refill = tick && (mcnt == (1 << rdiv) - 1);
      nl = (pkt_len > pkt_ofs) ? longint'(pkt_len) - longint'(pkt_ofs) : 0;
      cost = (lm ? 0 : nl * 256) + ((ae >= 24) ? 0 : ((longint'(am) - 256) * (longint'(1) << ae)));
      if (cost < 1) cost = 1;
      incol = (icol == 3) ? 0 : pkt_color;
      dc = 0; dp = 0;
      if (incol == 2) col = 2;
      else if (incol != 1 && mc >= cost) begin col = 0; dc = cost; end
      else if (mp >= cost) begin col = 1; dp = cost; end
      else col = 2;
      if (!pkt_valid) begin dc = 0; dp = 0; end
      ev = pkt_valid;
      ecol = col;
      eact = (col == 0) ? mr[3][17:16] : (col == 1) ? mr[3][19:18] : mr[3][21:20];
      if (mreload) begin
        mc = ccap; mp = pcap;
      end else begin
        mc = mc - dc + (refill ? crate : 0); if (mc > ccap) mc = ccap;
        mp = mp - dp + (refill ? prate : 0); if (mp > pcap) mp = pcap;
      end
      if (cfg_we) mcnt = 0;
      else if (tick) mcnt = refill ? 0 : mcnt + 1;
      mreload = cfg_we;
      if (cfg_we) mr[cfg_addr] = cfg_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (res_valid !== ev) begin
        errors++;
        $display("FAIL %s: res_valid=%0b expected %0b (R12)", cur_req, res_valid, ev);
      end else if (ev && (res_color !== 2'(ecol) || res_action !== 2'(eact))) begin
        errors++;
        $display("FAIL %s: color/action=%0d/%0d expected %0d/%0d", cur_req, res_color, res_action, ecol, eact);
      end
    end
  end

  task automatic chk(string req, int got, int exp_v);
    checks++;
    if (got != exp_v) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp_v);
    end
  endtask

  function automatic logic [31:0] bkt_word(int rm, int re, int dm, int de);
    return {3'd0, 5'(de), 8'(dm), 3'd0, 5'(re), 8'(rm)};
  endfunction

  function automatic logic [31:0] mode_word(int rdiv, int ic, int ga, int ya, int ra);
    return {10'd0, 2'(ra), 2'(ya), 2'(ga), 6'd0, 2'(ic), 4'd0, 4'(rdiv)};
  endfunction

  task automatic cfg(int a, logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(int len, int ofs, int c, bit tk);
    pkt_valid = 1'b1; pkt_len = 16'(len); pkt_ofs = 8'(ofs); pkt_color = 2'(c); tick = tk;
    @(negedge clk);
    pkt_valid = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 idle valid", res_valid, 0);
    send(64, 0, 0, 0);
    chk("R1 color", res_color, 2);
    chk("R1 action", res_action, 1);

    cur_req = "R11";
    cfg(0, bkt_word(0, 8, 0, 10));
    send(1000, 0, 0, 0);
    chk("R11 green after fill", res_color, 0);
    chk("R8 green action", res_action, 0);
    send(100, 0, 0, 0);
    chk("R8 red after debit", res_color, 2);
    chk("R7 no yellow with zero peak", res_action, 1);

    cur_req = "R3";
    for (int d = 0; d < 3; d++) begin
      cfg(3, mode_word(d, 3, 0, 0, 1));
      for (int k = 0; k < 12; k++) begin
        ticks(1);
        send(200, 0, 0, 0);
      end
    end

    cur_req = "R2";
    cfg(0, bkt_word(77, 3, 0, 10));
    send(1024, 0, 0, 0);
    for (int k = 0; k < 6; k++) begin ticks(1); send(300, 0, 0, 0); end

    cur_req = "R4";
    ticks(40);
    send(1024, 0, 0, 0);
    ticks(20);
    send(1025, 0, 0, 0);
    chk("R4 over cap is red", res_color, 2);

    cur_req = "R8";
    cfg(1, bkt_word(128, 6, 0, 11));
    for (int k = 0; k < 20; k++) send(400 + 37 * k, 0, 0, k % 3 == 0);

    cur_req = "R5";
    cfg(2, {7'd0, 1'b0, 3'd0, 5'd3, 7'd0, 9'd200});
    for (int k = 0; k < 10; k++) send(k, 4, 0, 0);
    send(10, 200, 0, 0);
    send(500, 20, 0, 1);
    cfg(2, {7'd0, 1'b0, 3'd0, 5'd2, 7'd0, 9'd300});
    for (int k = 0; k < 8; k++) send(150, k, 0, 0);
    cfg(2, {7'd0, 1'b0, 3'd0, 5'd30, 7'd0, 9'd0});
    send(120, 0, 0, 0);

    cur_req = "R6";
    cfg(0, bkt_word(0, 8, 0, 10));
    cfg(1, bkt_word(0, 24, 0, 24));
    cfg(2, {7'd0, 1'b1, 3'd0, 5'd1, 7'd0, 9'd384});
    for (int k = 0; k < 5; k++) send(1500, 0, 0, 0);
    chk("R6 packet cost one token", res_color, 0);

    cur_req = "R9";
    cfg(2, 32'd256);
    cfg(1, bkt_word(0, 8, 0, 12));
    cfg(3, mode_word(0, 0, 0, 0, 1));
    send(50, 0, 2, 0);
    chk("R9 incoming red stays red", res_color, 2);
    send(50, 0, 1, 0);
    chk("R9 incoming yellow skips committed", res_color, 1);
    send(50, 0, 0, 0);
    cfg(3, mode_word(0, 3, 0, 0, 1));
    send(50, 0, 2, 0);
    chk("R9 blind ignores color", res_color, 0);

    cur_req = "R10";
    cfg(3, mode_word(1, 3, 1, 2, 0));
    send(900, 0, 0, 0);
    chk("R10 green action remapped", res_action, 1);
    for (int k = 0; k < 6; k++) send(900, 0, 0, 0);

    cur_req = "R12";
    cfg(0, bkt_word(50, 9, 100, 11));
    cfg(1, bkt_word(10, 10, 20, 12));
    cfg(3, mode_word(2, 3, 0, 2, 1));
    for (int k = 0; k < 1500; k++) begin
      pkt_valid = ($urandom % 2) == 0;
      pkt_len = 16'($urandom % 2048);
      pkt_ofs = 8'($urandom % 64);
      pkt_color = 2'($urandom % 4);
      tick = ($urandom % 4) == 0;
      @(negedge clk);
    end
    pkt_valid = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule